// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from peripheral sources into a 16-bit status register and gates them with a 16-bit mask register. Any source can latch its status bit with a single-cycle request, and the DMA interrupt logic has its own dedicated request pulse. Software clears latched bits by writing a value that is bitwise ANDed into the status register: a 0 clears a bit and a 1 leaves it alone. The processor sees one level-sensitive pending line. It is high whenever a latched status bit is also enabled in the mask.

Both registers are reached through a simple register port. 16-bit and 32-bit accesses behave the same way, and only the low half of the data bus is used. A mask write that enables a source which is already latched raises a one-cycle unmask event. The processor side uses this event to look for a pending interrupt again at once, rather than waiting for the next status change.

Top module: `intc_top`

## Requirements
- R1: After synchronous reset, the status register, the mask register, `irq_pending`, `unmask_evt` and `bus_rdata` are all zero.
- R2: A 1 on bit i of `src_set` during a clock edge sets status bit i. A 1 on `dma_irq_pulse` sets status bit 3. Set bits stay set until software clears them.
- R3: A write to offset 0x070 (word address `bus_addr[11:2]` = 0x01C) replaces the status register with the old status ANDed with `bus_wdata[15:0]`.
- R4: If a source sets a status bit in the same cycle that a status write clears it, the bit ends up set.
- R5: A write to offset 0x074 (word address 0x01D) replaces the mask register with `bus_wdata[15:0]`.
- R6: `irq_pending` is 1 exactly when (status AND mask) is nonzero for the current register contents.
- R7: `unmask_evt` is high for one cycle, in the cycle after a mask write, exactly when (status before the write AND the new mask value) is nonzero. It is low at all other times.
- R8: `bus_wdata[31:16]` and `bus_addr[1:0]` have no effect. A 16-bit and a 32-bit write with the same low half give the same result. Writes to any other word address change nothing.
- R9: A read (`bus_rd`) loads `bus_rdata` at the next edge. At offset 0x070 it loads the status, at offset 0x074 the mask, and at any other address zero. Bits 31:16 are always zero, and `bus_rdata` holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Registered read data |
| src_set | input | 16 | Per-source status set requests |
| dma_irq_pulse | input | 1 | DMA interrupt request, sets status bit 3 |
| irq_pending | output | 1 | Any enabled status bit is set |
| unmask_evt | output | 1 | One-cycle pulse when a mask write uncovers a pending bit |

## Verification
The assertions check a number of properties on every cycle:
- a requested bit is latched the next cycle;
- an acknowledge with no concurrent request leaves exactly the ANDed value;
- a mask write lands verbatim;
- an unmask event only follows a mask write and always comes with the pending line high;
- the upper read half stays zero.

Some behaviours only the bench's scenarios can show:
- that a set beats a simultaneous clear;
- that the event is absent when the new mask hides every latched bit;
- that writes with junk upper halves or to foreign addresses leave both registers unchanged.

The behavioural reference model, compared every clock over a long random phase, covers mixed reads, writes and requests that no single property expresses.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W    = 16;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 12;
    localparam int DMA_BIT  = 3;
    localparam logic [ADDR_W-1:0] STAT_OFF = 12'h070;
    localparam logic [ADDR_W-1:0] MASK_OFF = 12'h074;
    localparam int WADDR_W  = ADDR_W - 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             stat_we;
        logic             mask_we;
        logic [REG_W-1:0] val;
    } wr_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [WADDR_W-1:0] waddr);
        reg_sel_e s;
        if (waddr == STAT_OFF[ADDR_W-1:2])
            s = SEL_STAT;
        else if (waddr == MASK_OFF[ADDR_W-1:2])
            s = SEL_MASK;
        else
            s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] zext_reg(input logic [REG_W-1:0] v);
        return {{(BUS_W-REG_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/intc_bus_decode.sv
module intc_bus_decode
    import intc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int RW = REG_W
) (
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output wr_cmd_t       wr_cmd,
    output reg_sel_e      rd_sel
);
    localparam int HI_W = DW - RW;

    reg_sel_e  addr_sel;
    logic      unused_bits;

    assign addr_sel    = decode_sel(bus_addr[AW-1:2]);
    assign unused_bits = ^{bus_wdata[DW-1:RW], bus_addr[1:0], HI_W[0]};

    always_comb begin
        wr_cmd.stat_we = bus_wr && (addr_sel == SEL_STAT);
        wr_cmd.mask_we = bus_wr && (addr_sel == SEL_MASK);
        wr_cmd.val     = bus_wdata[RW-1:0];
        rd_sel         = bus_rd ? addr_sel : SEL_NONE;
    end
endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg
    import intc_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int DMA_IX = DMA_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack_we,
    input  logic [W-1:0] ack_val,
    input  logic [W-1:0] src_set,
    input  logic         dma_pulse,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] set_vec;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == DMA_IX) begin : g_dma
            assign set_vec[i] = src_set[i] | dma_pulse;
        end else begin : g_src
            assign set_vec[i] = src_set[i];
        end

        logic keep;
        assign keep = !ack_we || ack_val[i];

        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else
                stat_q[i] <= (stat_q[i] && keep) || set_vec[i];
        end
    end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] val,
    input  logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q,
    output logic         evt_q
);
    logic exposes;
    assign exposes = |(stat_q & val);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            if (we)
                mask_q <= val;
            evt_q <= we && exposes;
        end
    end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  reg_sel_e      sel,
    input  logic [W-1:0]  stat_q,
    input  logic [W-1:0]  mask_q,
    output logic [DW-1:0] rdata_q
);
    logic [W-1:0] pick;

    always_comb begin
        unique case (sel)
            SEL_STAT: pick = stat_q;
            SEL_MASK: pick = mask_q;
            default:  pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= zext_reg(pick);
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  src_set,
    input  logic              dma_irq_pulse,
    output logic              irq_pending,
    output logic              unmask_evt
);
    wr_cmd_t          wr_cmd;
    reg_sel_e         rd_sel;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] mask_q;

    intc_bus_decode u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_cmd    (wr_cmd),
        .rd_sel    (rd_sel)
    );

    intc_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .ack_we    (wr_cmd.stat_we),
        .ack_val   (wr_cmd.val),
        .src_set   (src_set),
        .dma_pulse (dma_irq_pulse),
        .stat_q    (stat_q)
    );

    intc_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_cmd.mask_we),
        .val    (wr_cmd.val),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .evt_q  (unmask_evt)
    );

    intc_read_mux u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (bus_rd),
        .sel     (rd_sel),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .rdata_q (bus_rdata)
    );

    assign irq_pending = |(stat_q & mask_q);
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [REG_W-1:0]  src_set,
    input logic              dma_irq_pulse,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq_pending,
    input logic              unmask_evt
);
    logic [REG_W-1:0] req;
    logic             hit_stat;
    logic             hit_mask;

    always_comb begin
        req = src_set;
        req[DMA_BIT] = src_set[DMA_BIT] | dma_irq_pulse;
    end
    assign hit_stat = bus_wr && (bus_addr[ADDR_W-1:2] == STAT_OFF[ADDR_W-1:2]);
    assign hit_mask = bus_wr && (bus_addr[ADDR_W-1:2] == MASK_OFF[ADDR_W-1:2]);

    // R2 / R4: a request is latched regardless of a concurrent clear
    p_set_latched_r2: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> ((stat_q & $past(req)) == $past(req)));

    // R3: acknowledge with no concurrent request
    p_ack_and_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_stat && req == '0) |=> (stat_q == ($past(stat_q) & $past(bus_wdata[REG_W-1:0]))));

    // R5: mask write lands verbatim
    p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
        hit_mask |=> (mask_q == $past(bus_wdata[REG_W-1:0])));

    // R7: event only after a mask write
    p_evt_cause_r7: assert property (@(posedge clk) disable iff (rst)
        unmask_evt |-> $past(hit_mask));

    // R7 / R6: event always accompanied by a pending request
    p_evt_pending_r7: assert property (@(posedge clk) disable iff (rst)
        unmask_evt |-> irq_pending);

    // R9: upper read half is zero
    p_rd_hi_zero_r9: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:REG_W] == '0);
endmodule

bind intc_top intc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .src_set       (src_set),
    .dma_irq_pulse (dma_irq_pulse),
    .stat_q        (stat_q),
    .mask_q        (mask_q),
    .irq_pending   (irq_pending),
    .unmask_evt    (unmask_evt)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] src_set = '0;
    logic        dma_irq_pulse = 1'b0;
    logic        irq_pending;
    logic        unmask_evt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_stat = '0;
    logic [15:0] m_mask = '0;
    logic        m_evt  = 1'b0;
    logic [31:0] m_rd   = '0;

    always #10 clk = ~clk;  // 50 MHz

    intc_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_set(src_set), .dma_irq_pulse(dma_irq_pulse),
        .irq_pending(irq_pending), .unmask_evt(unmask_evt)
    );

    // behavioural reference, updated on each edge from the bench's own inputs
    always @(posedge clk) begin
        logic [15:0] ns;
        logic [15:0] nm;
        logic        hs, hm;
        hs = bus_wr && (bus_addr >> 2) == (12'h070 >> 2);
        hm = bus_wr && (bus_addr >> 2) == (12'h074 >> 2);
        if (rst) begin
            m_stat = '0; m_mask = '0; m_evt = 0; m_rd = '0;
        end else begin
            if (bus_rd) begin
                if ((bus_addr >> 2) == (12'h070 >> 2))      m_rd = {16'h0, m_stat};
                else if ((bus_addr >> 2) == (12'h074 >> 2)) m_rd = {16'h0, m_mask};
                else                                          m_rd = '0;
            end
            ns = m_stat;
            if (hs) ns = ns & bus_wdata[15:0];
            ns = ns | src_set;
            if (dma_irq_pulse) ns[3] = 1'b1;
            nm = hm ? bus_wdata[15:0] : m_mask;
            m_evt  = hm && ((m_stat & bus_wdata[15:0]) != 0);
            m_stat = ns;
            m_mask = nm;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 pending", {31'b0, irq_pending}, {31'b0, (m_stat & m_mask) != 0});
            chk("R7 unmask_evt", {31'b0, unmask_evt}, {31'b0, m_evt});
            chk("R9 rdata", bus_rdata, m_rd);
        end
    end

    task automatic idle();
        bus_wr = 0; bus_rd = 0; src_set = '0; dma_irq_pulse = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); idle();
    endtask

    // issues a read; after return bus_rdata holds the result
    task automatic rd(input logic [11:0] a);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", bus_rdata, 32'h0);
        chk("R1 reset pending", {31'b0, irq_pending}, 32'h0);
        rst = 0;
        rd(12'h070); chk("R1 status zero", bus_rdata, 32'h0);
        rd(12'h074); chk("R1 mask zero", bus_rdata, 32'h0);

        // R2: source sets
        @(negedge clk); src_set = 16'h0005;
        @(negedge clk); idle();
        rd(12'h070); chk("R2 src set", bus_rdata, 32'h0005);
        @(negedge clk); dma_irq_pulse = 1;
        @(negedge clk); idle();
        rd(12'h070); chk("R2 dma bit3", bus_rdata, 32'h000D);

        // R7: mask write exposing bit 2, 16-bit style
        @(negedge clk); bus_wr = 1; bus_addr = 12'h074; bus_wdata = 32'h0000_0004;
        @(negedge clk); idle();
        chk("R7 evt after exposing write", {31'b0, unmask_evt}, 32'h1);
        chk("R6 pending after unmask", {31'b0, irq_pending}, 32'h1);
        @(negedge clk);
        chk("R7 evt one cycle", {31'b0, unmask_evt}, 32'h0);

        // R3 / R8: 32-bit clear with junk upper half
        wr(12'h070, 32'hABCD_FFFB);
        rd(12'h070); chk("R3 ack clears bit2", bus_rdata, 32'h0009);
        chk("R6 pending dropped", {31'b0, irq_pending}, 32'h0);

        // R7: mask write that hides everything: no event
        @(negedge clk); bus_wr = 1; bus_addr = 12'h074; bus_wdata = 32'h0000_0002;
        @(negedge clk); idle();
        chk("R7 no evt when hidden", {31'b0, unmask_evt}, 32'h0);
        rd(12'h074); chk("R5 mask replaced", bus_rdata, 32'h0002);

        // R4: set and clear of bit1 in the same cycle
        @(negedge clk); bus_wr = 1; bus_addr = 12'h070; bus_wdata = 32'h0; src_set = 16'h0002;
        @(negedge clk); idle();
        rd(12'h070); chk("R4 set wins", bus_rdata, 32'h0002);
        chk("R4 pending", {31'b0, irq_pending}, 32'h1);

        // R8: 32-bit mask write with upper ones; offset 0x076 aliases the same word
        wr(12'h076, 32'hFFFF_FFFF);
        rd(12'h074); chk("R8 upper ignored", bus_rdata, 32'h0000_FFFF);
        wr(12'h078, 32'h0000_0000);
        rd(12'h074); chk("R8 foreign write ignored mask", bus_rdata, 32'h0000_FFFF);
        rd(12'h070); chk("R8 foreign write ignored stat", bus_rdata, 32'h0002);
        rd(12'h07C); chk("R9 other addr reads zero", bus_rdata, 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 rdata holds", bus_rdata, 32'h0);

        // random phase, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_wr        = ($urandom % 3) == 0;
            bus_rd        = ($urandom % 2) == 0;
            bus_addr      = 12'h070 + 12'(($urandom % 4) * 4);
            bus_wdata     = $urandom;
            src_set       = (($urandom % 4) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
            dma_irq_pulse = ($urandom % 8) == 0;
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule